// File: doc/BRIEF.md
# Operand Cache Tag Store with Direct Access

This block holds the tags and the line data of a direct-mapped operand cache with 512 entries of 32 bytes each. Software reaches both arrays through one register-style access port. A select bit picks the tag array or the data array, and the byte address picks the entry and the word. Each tag entry holds a physical tag field together with a valid flag and a dirty flag.

A direct write to a tag entry installs a new tag and new flags. If the entry it replaces is both valid and dirty, the block first pushes that line out to memory. It does this as a burst of eight 32-bit beats on a valid/ready write master, and it installs the new tag only after the last beat has been accepted. A pulse on the invalidate input starts a sweep that clears the valid and dirty flags of every entry, one entry per cycle. While a sweep or a write-back is in progress, the block reports busy and holds off the access port.

Top module: `octag_store`

## Requirements
- R1: After reset, busy and wb_valid are low, acc_ready is high, and every tag entry reads back with flag bits [1:0] equal to 0.
- R2: A tag access (acc_sel=0) uses byte address bits [13:5] as the entry index. A direct tag write (address bit 3 clear) stores acc_wdata AND 0x1FFFFC03, so the tag field sits in bits [28:10], the valid flag in bit 0 and the dirty flag in bit 1. A later tag read returns exactly that word.
- R3: A read is accepted in the cycle where acc_req and acc_ready are both high. In the next cycle acc_rvalid is high for exactly one cycle and carries the data. No acc_rvalid appears without an accepted read.
- R4: A data access (acc_sel=1) reads or writes the 32-bit word selected by byte address bits [13:2]. Entry n, word w is at byte address n*32 + w*4.
- R5: A tag write with address bit 3 set changes no tag, no flag and no data, and it starts no write-back.
- R6: A direct tag write that hits an entry whose old flags are both valid and dirty emits 8 beats on the write master. Beat b has wb_addr = {old tag bits [28:10], index bits [4:0] at bits [9:5], b at bits [4:2], 00} and wb_data equal to data word b of that entry. wb_last is high only on beat 7.
- R7: A beat stays presented with stable wb_addr and wb_data until wb_ready accepts it. The new tag becomes readable only after the last beat is accepted, and acc_ready stays low until then.
- R8: A direct tag write over an entry that is not both valid and dirty (valid and clean, dirty without valid, or invalid) emits no beats and installs the new tag at once.
- R9: A one-cycle pulse on inval_req while idle keeps busy high for exactly 512 cycles. Afterwards every entry reads with flag bits [1:0] equal to 0 and its tag bits unchanged. A later tag write over a previously dirty entry then starts no write-back.
- R10: acc_ready is low whenever busy is high or inval_req is high, so no access is accepted during a sweep or a write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_req | input | 1 | Access request |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 1 | 0 = tag array, 1 = data array |
| acc_addr | input | 12 | Byte address bits [13:2] |
| acc_wdata | input | 32 | Write data |
| acc_ready | output | 1 | Access accepted when high together with acc_req |
| acc_rvalid | output | 1 | Read data valid, one cycle after acceptance |
| acc_rdata | output | 32 | Read data |
| inval_req | input | 1 | Start an invalidate sweep |
| busy | output | 1 | Sweep or write-back in progress |
| wb_valid | output | 1 | Write-back beat valid |
| wb_ready | input | 1 | Write-back beat accepted |
| wb_addr | output | 32 | Write-back beat byte address |
| wb_data | output | 32 | Write-back beat data |
| wb_last | output | 1 | Final beat of the burst |

## Verification
The bench stalls wb_ready in an irregular pattern during every burst. A design that advances a beat without a handshake would skip or repeat a word in the beat stream, and one that installs the tag early would return the new tag before the burst drains. It replaces entries that are valid-clean, dirty-but-invalid and invalid, so a design that tests only one flag would emit a spurious burst. It issues an associative-mode write, which a design that ignores bit 3 would store. It also uses an index above 31 whose low bits differ from its high bits, so taking the wrong index bits into the write-back address shows up as a wrong wb_addr. After a sweep it counts the busy cycles and re-reads the old tags, so an early-ending sweep, or one that also erases the tag field, is exposed.

// File: rtl/octag_pkg.sv
package octag_pkg;
    // field layout of a tag word as seen on the access port
    localparam int TAG_LO    = 10;
    localparam int TAG_HI    = 28;
    localparam int TAG_W     = TAG_HI - TAG_LO + 1;
    localparam int TOP_PAD   = 31 - TAG_HI;
    localparam int MID_PAD   = TAG_LO - 2;
    localparam int BIT_VALID = 0;
    localparam int BIT_DIRTY = 1;
    localparam int BIT_ASSOC = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SWEEP = 2'd1,
        ST_WB    = 2'd2
    } octag_state_e;
endpackage

// File: rtl/octag_ram.sv
module octag_ram #(
    parameter int DEPTH = 512,
    parameter int WIDTH = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/octag_store.sv
module octag_store
    import octag_pkg::*;
#(
    parameter int ENTRIES    = 512,
    parameter int LINE_WORDS = 8,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int BEAT_W = $clog2(LINE_WORDS),
    localparam int WIDX_W = IDX_W + BEAT_W,
    localparam int AHI    = WIDX_W + 1,
    localparam int LOWI   = TAG_LO - BEAT_W - 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           acc_req,
    input  logic           acc_we,
    input  logic           acc_sel,
    input  logic [AHI:2]   acc_addr,
    input  logic [31:0]    acc_wdata,
    output logic           acc_ready,
    output logic           acc_rvalid,
    output logic [31:0]    acc_rdata,
    input  logic           inval_req,
    output logic           busy,
    output logic           wb_valid,
    input  logic           wb_ready,
    output logic [31:0]    wb_addr,
    output logic [31:0]    wb_data,
    output logic           wb_last
);
    typedef struct packed {
        octag_state_e       st;
        logic [IDX_W-1:0]   sweep;
        logic [IDX_W-1:0]   line;
        logic [BEAT_W-1:0]  beat;
        logic [TAG_W-1:0]   old_tag;
        logic [TAG_W-1:0]   new_tag;
        logic [1:0]         new_flags;
        logic               pend;
        logic               rvalid;
        logic [31:0]        rdata;
        logic [ENTRIES-1:0] valid;
        logic [ENTRIES-1:0] dirty;
    } regs_t;

    regs_t r_q, r_d;

    logic [IDX_W-1:0]  acc_idx;
    logic [WIDX_W-1:0] acc_widx;
    logic              acc_fire;
    logic              beat_end;

    logic              tag_we;
    logic [IDX_W-1:0]  tag_wa;
    logic [TAG_W-1:0]  tag_wd;
    logic [TAG_W-1:0]  tag_rd;
    logic              dat_we;
    logic [WIDX_W-1:0] dat_ra;
    logic [31:0]       dat_rd;
    logic [31:0]       tag_word;

    assign acc_idx  = acc_addr[AHI:BEAT_W+2];
    assign acc_widx = acc_addr[AHI:2];
    assign beat_end = (r_q.beat == BEAT_W'(LINE_WORDS - 1));

    assign busy      = (r_q.st != ST_IDLE);
    assign acc_ready = (r_q.st == ST_IDLE) && !inval_req && !r_q.pend;
    assign acc_fire  = acc_req && acc_ready;

    octag_ram #(.DEPTH(ENTRIES), .WIDTH(TAG_W)) u_tag_ram (
        .clk   (clk),
        .we    (tag_we),
        .waddr (tag_wa),
        .wdata (tag_wd),
        .raddr (acc_idx),
        .rdata (tag_rd)
    );

    octag_ram #(.DEPTH(ENTRIES * LINE_WORDS), .WIDTH(32)) u_dat_ram (
        .clk   (clk),
        .we    (dat_we),
        .waddr (acc_widx),
        .wdata (acc_wdata),
        .raddr (dat_ra),
        .rdata (dat_rd)
    );

    assign tag_word = {{TOP_PAD{1'b0}}, tag_rd, {MID_PAD{1'b0}},
                       r_q.dirty[acc_idx], r_q.valid[acc_idx]};

    always_comb begin
        r_d      = r_q;
        r_d.rvalid = 1'b0;
        tag_we   = 1'b0;
        tag_wa   = acc_idx;
        tag_wd   = acc_wdata[TAG_HI:TAG_LO];
        dat_we   = 1'b0;
        dat_ra   = acc_widx;

        unique case (r_q.st)
            ST_IDLE: begin
                if (inval_req || r_q.pend) begin
                    r_d.st    = ST_SWEEP;
                    r_d.sweep = '0;
                    r_d.pend  = 1'b0;
                end else if (acc_fire) begin
                    if (!acc_we) begin
                        r_d.rvalid = 1'b1;
                        r_d.rdata  = acc_sel ? dat_rd : tag_word;
                    end else if (acc_sel) begin
                        dat_we = 1'b1;
                    end else if (!acc_addr[BIT_ASSOC]) begin
                        if (r_q.valid[acc_idx] && r_q.dirty[acc_idx]) begin
                            r_d.st        = ST_WB;
                            r_d.line      = acc_idx;
                            r_d.beat      = '0;
                            r_d.old_tag   = tag_rd;
                            r_d.new_tag   = acc_wdata[TAG_HI:TAG_LO];
                            r_d.new_flags = {acc_wdata[BIT_DIRTY], acc_wdata[BIT_VALID]};
                        end else begin
                            tag_we = 1'b1;
                            r_d.valid[acc_idx] = acc_wdata[BIT_VALID];
                            r_d.dirty[acc_idx] = acc_wdata[BIT_DIRTY];
                        end
                    end
                end
            end
            ST_SWEEP: begin
                r_d.valid[r_q.sweep] = 1'b0;
                r_d.dirty[r_q.sweep] = 1'b0;
                r_d.sweep = r_q.sweep + 1'b1;
                if (r_q.sweep == IDX_W'(ENTRIES - 1)) begin
                    r_d.st = ST_IDLE;
                end
            end
            ST_WB: begin
                dat_ra = {r_q.line, r_q.beat};
                if (wb_ready) begin
                    r_d.beat = r_q.beat + 1'b1;
                    if (beat_end) begin
                        tag_we = 1'b1;
                        tag_wa = r_q.line;
                        tag_wd = r_q.new_tag;
                        r_d.valid[r_q.line] = r_q.new_flags[0];
                        r_d.dirty[r_q.line] = r_q.new_flags[1];
                        r_d.st = ST_IDLE;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        if (inval_req && (r_q.st != ST_IDLE)) begin
            r_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign acc_rvalid = r_q.rvalid;
    assign acc_rdata  = r_q.rdata;
    assign wb_valid   = (r_q.st == ST_WB);
    assign wb_last    = wb_valid && beat_end;
    assign wb_data    = dat_rd;
    assign wb_addr    = {{TOP_PAD{1'b0}}, r_q.old_tag, r_q.line[LOWI-1:0], r_q.beat, 2'b00};
endmodule

// File: rtl/octag_checker.sv
module octag_checker #(
    parameter int ENTRIES    = 512,
    parameter int LINE_WORDS = 8,
    localparam int AHI = $clog2(ENTRIES) + $clog2(LINE_WORDS) + 1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         acc_req,
    input logic         acc_we,
    input logic         acc_sel,
    input logic [AHI:2] acc_addr,
    input logic [31:0]  acc_wdata,
    input logic         acc_ready,
    input logic         acc_rvalid,
    input logic [31:0]  acc_rdata,
    input logic         inval_req,
    input logic         busy,
    input logic         wb_valid,
    input logic         wb_ready,
    input logic [31:0]  wb_addr,
    input logic [31:0]  wb_data,
    input logic         wb_last
);
    AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && acc_ready && !acc_we |=> acc_rvalid); // R3

    AST_NO_STRAY_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_req && acc_ready && !acc_we) |=> !acc_rvalid); // R3

    AST_BEAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr) && $stable(wb_data)); // R7

    AST_BEAT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && wb_ready && !wb_last |=> wb_valid && (wb_addr == $past(wb_addr) + 32'd4)); // R6

    AST_BURST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && wb_ready && wb_last |=> !wb_valid); // R6

    AST_WB_IS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> busy && !acc_ready); // R7

    AST_STALL_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy || inval_req |-> !acc_ready); // R10
endmodule

bind octag_store octag_checker #(.ENTRIES(ENTRIES), .LINE_WORDS(LINE_WORDS)) u_octag_checker (.*);

// File: tb/test_octag_store.sv
module test_octag_store;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_req = 1'b0;
    logic        acc_we = 1'b0;
    logic        acc_sel = 1'b0;
    logic [13:2] acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic        acc_ready;
    logic        acc_rvalid;
    logic [31:0] acc_rdata;
    logic        inval_req = 1'b0;
    logic        busy;
    logic        wb_valid;
    logic        wb_ready = 1'b0;
    logic [31:0] wb_addr;
    logic [31:0] wb_data;
    logic        wb_last;

    always #10 clk = ~clk;

    octag_store i_octag_store (
        .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_we(acc_we), .acc_sel(acc_sel),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_ready(acc_ready),
        .acc_rvalid(acc_rvalid), .acc_rdata(acc_rdata), .inval_req(inval_req),
        .busy(busy), .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr),
        .wb_data(wb_data), .wb_last(wb_last)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // reference model
    logic [31:0] tagm [512];
    bit          tag_known [512];
    logic [31:0] datm [4096];
    int unsigned exp_addr [$];
    int unsigned exp_data [$];
    int          exp_beat = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // write-master responder with irregular stalls, and per-cycle comparison
    always @(negedge clk) begin
        cyc++;
        wb_ready = (cyc % 3) != 1;
        if (rst_n) begin
            if (busy && acc_ready) check("R10 ready while busy", 32'(acc_ready), 32'd0);
            if (wb_valid && wb_ready) begin
                if (exp_addr.size() == 0) begin
                    check("R8 unexpected beat", wb_addr, 32'hFFFF_FFFF);
                end else begin
                    check("R6 beat addr", wb_addr, exp_addr.pop_front());
                    check("R6 beat data", wb_data, exp_data.pop_front());
                    check("R6 last flag", 32'(wb_last), 32'(exp_beat == 7));
                    exp_beat = (exp_beat + 1) % 8;
                end
            end
        end
    end

    task automatic do_acc(input bit we, input bit sel, input int unsigned a, input logic [31:0] d);
        acc_req = 1'b1; acc_we = we; acc_sel = sel; acc_addr = a[13:2]; acc_wdata = d;
        forever begin
            bit rdy;
            rdy = acc_ready;
            @(posedge clk);
            @(negedge clk);
            if (rdy) break;
        end
        acc_req = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic tag_wr(input int idx, input logic [31:0] val, input bit assoc);
        if (!assoc) begin
            if (tag_known[idx] && tagm[idx][1:0] == 2'b11) begin
                for (int b = 0; b < 8; b++) begin
                    exp_addr.push_back((tagm[idx] & 32'h1FFF_FC00) | ((idx % 32) << 5) | (b << 2));
                    exp_data.push_back(datm[idx * 8 + b]);
                end
            end
            tagm[idx] = val & 32'h1FFF_FC03;
            tag_known[idx] = 1'b1;
        end
        do_acc(1'b1, 1'b0, (idx << 5) | (assoc ? 8 : 0), val);
        wait_idle();
        check("R7 burst drained", 32'(exp_addr.size()), 32'd0);
    endtask

    task automatic tag_chk(input string req, input int idx);
        do_acc(1'b0, 1'b0, idx << 5, 32'd0);
        check(req, 32'(acc_rvalid), 32'd1);
        if (tag_known[idx]) check(req, acc_rdata, tagm[idx]);
        else check(req, acc_rdata & 32'h3, 32'h0);
    endtask

    task automatic dat_wr(input int widx, input logic [31:0] v);
        datm[widx] = v;
        do_acc(1'b1, 1'b1, widx << 2, v);
    endtask

    task automatic dat_chk(input int widx);
        do_acc(1'b0, 1'b1, widx << 2, 32'd0);
        check("R4 data rvalid", 32'(acc_rvalid), 32'd1);
        check("R4 data read", acc_rdata, datm[widx]);
    endtask

    task automatic fill_line(input int idx, input int seed);
        for (int w = 0; w < 8; w++) dat_wr(idx * 8 + w, 32'(seed * 32'h0101_0101 + w * 32'h11));
    endtask

    task automatic run_tests();
        int n;
        for (int i = 0; i < 512; i++) tag_known[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy", 32'(busy), 32'd0);
        check("R1 wb_valid", 32'(wb_valid), 32'd0);
        check("R1 ready", 32'(acc_ready), 32'd1);
        check("R3 idle rvalid", 32'(acc_rvalid), 32'd0);
        tag_chk("R1 flags", 0);
        tag_chk("R1 flags", 5);
        tag_chk("R1 flags", 511);

        tag_wr(3, 32'hFFFF_FFFF, 1'b0);
        tag_chk("R2 mask", 3);
        tag_wr(7, 32'hA5A5_5A5A, 1'b0);
        tag_chk("R2 mask", 7);
        @(negedge clk);
        check("R3 single pulse", 32'(acc_rvalid), 32'd0);

        dat_wr(0, 32'hDEAD_BEEF);
        dat_wr(4095, 32'h1234_5678);
        dat_wr(5 * 8 + 2, 32'hCAFE_0002);
        dat_chk(0);
        dat_chk(4095);
        dat_chk(5 * 8 + 2);

        tag_wr(3, 32'h0000_0000, 1'b1);
        tag_chk("R5 assoc ignored", 3);

        fill_line(3, 3);
        tag_wr(3, 32'h00AB_C401, 1'b0);
        tag_chk("R7 new tag after burst", 3);
        tag_wr(300, 32'h0123_4403, 1'b0);
        fill_line(300, 9);
        tag_wr(300, 32'h0000_0003, 1'b0);
        tag_chk("R6 second burst", 300);
        dat_chk(300 * 8 + 7);

        tag_wr(7, 32'h0000_0C01, 1'b0);
        tag_chk("R8 dirty-only", 7);
        tag_wr(7, 32'h0000_0401, 1'b0);
        tag_chk("R8 valid-clean", 7);

        fill_line(300, 21);
        inval_req = 1'b1;
        @(negedge clk);
        inval_req = 1'b0;
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
        check("R9 sweep length", 32'(n), 32'd512);
        for (int i = 0; i < 512; i++) if (tag_known[i]) tagm[i] = tagm[i] & ~32'h3;
        tag_chk("R9 flags cleared", 300);
        tag_chk("R9 flags cleared", 3);
        tag_chk("R9 flags cleared", 100);
        tag_wr(300, 32'h0777_7403, 1'b0);
        tag_chk("R9 no burst after sweep", 300);
        check("R6 no leftover beats", 32'(exp_addr.size()), 32'd0);
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (100000) @(posedge clk);
                errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule